// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a sixteen-key matrix keypad arranged as four rows by four columns. It pulls one row low at a time and reads the four column lines back through a two-flop synchronizer. Over one full pass of the four rows, it turns the combination of the active row and a single low column into a 5-bit key code. The pass result is the frame code. When no key is pressed, or the column pattern is ambiguous, the frame code is the idle value 5'h1F.

A slower sampler writes frame codes into a rotating set of slots. The output code changes only when every slot holds the same value. A one-clock valid strobe marks the moment a real key replaces the idle code, so a held key produces exactly one event. Downstream logic reads codes 0 to 9 as digits, 10, 11 and 12 as add, subtract and multiply, and 13 as equals. It ignores the idle value.

Both the row-step and the sample period come from internal clock-enable counters. Their defaults suit a 125 MHz clock: about 4 kHz scanning and 10 Hz sampling, so eight agreeing samples span far longer than contact bounce.

Top module: `keypad_scanner`

## Requirements
- R1: After reset `row_n_o` is 4'b0111. Every SCAN_DIV clocks it steps through 1110, 1101, 1011, 0111 and repeats; the new value appears one clock after a row-step tick.
- R2: A key on the row whose `row_n_o` bit r is low and the column whose `col_n_i` bit c is low produces code 4*r + c. Row bit 0 with column bit 0 is code 0, and row bit 3 with column bit 3 is code 15.
- R3: The idle code is 5'h1F. A frame in which no row step saw exactly one low column publishes 5'h1F. More than one low column in a step counts as no key.
- R4: Columns pass through two flops before use. A column is read on the last clock of its row step. The frame code is published at the end of the 0111 step and reflects the last valid read in that frame.
- R5: Every SAMPLE_DIV clocks the current frame code is written into the next of NSLOTS slots in rotation. `key_code_o` takes the slot value one clock after all slots agree, and changes at no other time.
- R6: `key_valid_o` is high for exactly one clock, in the same cycle that `key_code_o` changes from 5'h1F to a key code. A held key gives one pulse. A direct change from one key to another gives none.
- R7: After release, `key_code_o` returns to 5'h1F once NSLOTS idle samples agree, with no strobe.
- R8: A synchronous reset sets the row counter to its 0111 state, fills all slots and the output code with 5'h1F, and holds `key_valid_o` low, even while a key is held.
- R9: Input that toggles between a key and idle faster than NSLOTS sample periods leaves `key_code_o` unchanged and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| col_n_i | input | 4 | Column read-back, active low |
| row_n_o | output | 4 | Row drive, active low, one row at a time |
| key_code_o | output | 5 | Debounced key code, 5'h1F when idle |
| key_valid_o | output | 1 | One-clock strobe on a new key |

## Verification
Two functions can fall in the same cycle. A row-step tick can publish a new frame code while the sampler writes a slot, and the agreement check can update the output code while the next sample is being written. Small divider values on the bench make these coincidences frequent: a 16-clock frame against a 20-clock sample period. A behavioural model that steps the same rules on integers is compared with the row drive, code and strobe on every clock. Bounce trains, key-to-key switches, two-column presses and a reset during a held key are run. After each phase the bench judges the settled code and the number of strobes seen.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
    localparam int CODE_W = 5;
    localparam int LINES  = 4;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t KEY_NONE = 5'h1F;

    // index of the lowest zero bit
    function automatic logic [1:0] low_index(input logic [LINES-1:0] v);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!v[i]) idx = 2'(i);
        end
        return idx;
    endfunction

    // exactly one bit low
    function automatic logic single_low(input logic [LINES-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < LINES; i++) begin
            if (!v[i]) n++;
        end
        return (n == 1);
    endfunction
endpackage

// File: rtl/keypad_tick.sv
module keypad_tick #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    assign tick_o = (s_q.cnt == CW'(DIV - 1));

    always_comb begin
        s_d = s_q;
        if (tick_o) s_d.cnt = '0;
        else        s_d.cnt = s_q.cnt + CW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end
endmodule

// File: rtl/keypad_sync.sv
module keypad_sync #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    typedef struct packed {
        logic [W-1:0] m1;
        logic [W-1:0] m2;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.m1 = din_i;
        s_d.m2 = s_q.m1;
    end

    assign dout_o = s_q.m2;

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{m1: '1, m2: '1};
        else       s_q <= s_d;
    end
endmodule

// File: rtl/keypad_rowscan.sv
module keypad_rowscan
    import keypad_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [LINES-1:0] col_s_i,
    output logic [LINES-1:0] row_n_o,
    output code_t            frame_o
);
    typedef struct packed {
        logic [1:0] rcnt;
        code_t      hit;
        code_t      frame;
    } scan_st_t;

    scan_st_t   s_d, s_q;
    logic [1:0] row_idx;
    logic       pat_ok;
    code_t      pat_code;
    code_t      cand;

    // counter 01 selects row bit 0, 00 selects row bit 3
    assign row_idx  = s_q.rcnt - 2'd1;
    assign row_n_o  = ~(4'b0001 << row_idx);
    assign pat_ok   = single_low(col_s_i);
    assign pat_code = {1'b0, row_idx, low_index(col_s_i)};
    assign cand     = pat_ok ? pat_code : s_q.hit;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            s_d.rcnt = s_q.rcnt + 2'd1;
            if (s_q.rcnt == 2'b00) begin
                s_d.frame = cand;
                s_d.hit   = KEY_NONE;
            end else begin
                s_d.hit   = cand;
            end
        end
    end

    assign frame_o = s_q.frame;

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{rcnt: 2'b00, hit: KEY_NONE, frame: KEY_NONE};
        else       s_q <= s_d;
    end
endmodule

// File: rtl/keypad_debounce.sv
module keypad_debounce
    import keypad_pkg::*;
#(
    parameter int NSLOTS = 8
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    input  code_t frame_i,
    output code_t code_o,
    output logic  valid_o
);
    localparam int PW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

    typedef struct packed {
        code_t [NSLOTS-1:0] slot;
        logic  [PW-1:0]     ptr;
        code_t              code;
        logic               valid;
    } deb_st_t;

    deb_st_t           s_d, s_q;
    logic [NSLOTS-1:0] same;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_cmp
        assign same[i] = (s_q.slot[i] == s_q.slot[0]);
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (&same) begin
            s_d.code  = s_q.slot[0];
            s_d.valid = (s_q.slot[0] != KEY_NONE) && (s_q.code == KEY_NONE);
        end
        if (tick_i) begin
            s_d.slot[s_q.ptr] = frame_i;
            s_d.ptr = (s_q.ptr == PW'(NSLOTS - 1)) ? '0 : s_q.ptr + PW'(1);
        end
    end

    assign code_o  = s_q.code;
    assign valid_o = s_q.valid;

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{slot: {NSLOTS{KEY_NONE}}, ptr: '0, code: KEY_NONE, valid: 1'b0};
        else       s_q <= s_d;
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int SCAN_DIV   = 31250,
    parameter int SAMPLE_DIV = 12500000,
    parameter int NSLOTS     = 8
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [3:0]  col_n_i,
    output logic [3:0]  row_n_o,
    output logic [4:0]  key_code_o,
    output logic        key_valid_o
);
    logic [LINES-1:0] col_s;
    logic             scan_tick;
    logic             sample_tick;
    code_t            frame_code;

    keypad_tick #(.DIV(SCAN_DIV)) u_scan_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(scan_tick)
    );

    keypad_tick #(.DIV(SAMPLE_DIV)) u_sample_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(sample_tick)
    );

    keypad_sync #(.W(LINES)) u_col_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .din_i (col_n_i),
        .dout_o(col_s)
    );

    keypad_rowscan u_rowscan (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (scan_tick),
        .col_s_i(col_s),
        .row_n_o(row_n_o),
        .frame_o(frame_code)
    );

    keypad_debounce #(.NSLOTS(NSLOTS)) u_debounce (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (sample_tick),
        .frame_i(frame_code),
        .code_o (key_code_o),
        .valid_o(key_valid_o)
    );
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [3:0] row_n_o,
    input logic [4:0] key_code_o,
    input logic       key_valid_o,
    input logic       scan_tick,
    input logic       sample_tick
);
    // R1
    row_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(row_n_o) |-> $past(scan_tick));

    // R1
    row_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(row_n_o) |-> row_n_o == {$past(row_n_o[2:0]), $past(row_n_o[3])});

    // R5
    code_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(key_code_o) |-> $past(sample_tick, 2));

    // R6
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        key_valid_o |=> !key_valid_o);

    // R6
    strobe_from_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        key_valid_o |-> (key_code_o != 5'h1F) && ($past(key_code_o) == 5'h1F));
endmodule

bind keypad_scanner keypad_scanner_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .row_n_o    (row_n_o),
    .key_code_o (key_code_o),
    .key_valid_o(key_valid_o),
    .scan_tick  (scan_tick),
    .sample_tick(sample_tick)
);

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
    localparam int SD = 4;
    localparam int PD = 20;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mask = '0;
    logic [3:0]  col_n;
    logic [3:0]  row_n;
    logic [4:0]  code;
    logic        valid;

    int total = 0;
    int bad   = 0;
    int pulses = 0;

    always #4 clk = ~clk;

    // keypad: column c low when a pressed key sits on a driven row
    function automatic logic [3:0] pad(input logic [3:0] rown, input logic [15:0] mk);
        logic [3:0] c;
        c = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 4; k++)
                if (mk[r*4+k] && !rown[r]) c[k] = 1'b0;
        return c;
    endfunction

    always_comb col_n = pad(row_n, mask);

    keypad_scanner #(.SCAN_DIV(SD), .SAMPLE_DIV(PD), .NSLOTS(NS)) u_keypad_scanner (
        .clk_i      (clk),
        .rst_i      (rst),
        .col_n_i    (col_n),
        .row_n_o    (row_n),
        .key_code_o (code),
        .key_valid_o(valid)
    );

    // reference model state
    int         m_scnt, m_rcnt, m_hit, m_frame, m_pcnt, m_ptr, m_code;
    int         m_slot [NS];
    bit         m_valid;
    logic [3:0] m_s1, m_s2;

    function automatic logic [3:0] m_row(input int rc);
        return ~(4'b0001 << ((rc + 3) % 4));
    endfunction

    function automatic int m_pat(input logic [3:0] rown, input logic [3:0] coln);
        int r, c, n;
        r = -1; c = -1; n = 0;
        for (int i = 0; i < 4; i++) if (!rown[i]) r = i;
        for (int i = 0; i < 4; i++) if (!coln[i]) begin n++; c = i; end
        if (n == 1 && r >= 0) return r * 4 + c;
        return -1;
    endfunction

    task automatic m_reset();
        m_scnt = 0; m_rcnt = 0; m_hit = 31; m_frame = 31; m_pcnt = 0;
        m_ptr = 0; m_code = 31; m_valid = 1'b0; m_s1 = 4'hF; m_s2 = 4'hF;
        for (int i = 0; i < NS; i++) m_slot[i] = 31;
    endtask

    initial m_reset();

    always @(posedge clk) begin : model
        bit st, pt, eq;
        int pc, cand, n_hit, n_frame, n_rcnt, n_code;
        bit n_valid;
        logic [3:0] n_s1;
        if (rst) begin
            m_reset();
        end else begin
            st = (m_scnt == SD - 1);
            pt = (m_pcnt == PD - 1);
            n_hit = m_hit; n_frame = m_frame; n_rcnt = m_rcnt;
            if (st) begin
                pc   = m_pat(m_row(m_rcnt), m_s2);
                cand = (pc >= 0) ? pc : m_hit;
                if (m_rcnt == 0) begin n_frame = cand; n_hit = 31; end
                else n_hit = cand;
                n_rcnt = (m_rcnt + 1) % 4;
            end
            eq = 1'b1;
            for (int i = 1; i < NS; i++) if (m_slot[i] != m_slot[0]) eq = 1'b0;
            n_code = m_code; n_valid = 1'b0;
            if (eq) begin
                n_code  = m_slot[0];
                n_valid = (m_slot[0] != 31) && (m_code == 31);
            end
            if (pt) begin
                m_slot[m_ptr] = m_frame;
                m_ptr = (m_ptr + 1) % NS;
            end
            n_s1 = pad(m_row(m_rcnt), mask);
            m_s2 = m_s1; m_s1 = n_s1;
            m_scnt = st ? 0 : m_scnt + 1;
            m_pcnt = pt ? 0 : m_pcnt + 1;
            m_hit = n_hit; m_frame = n_frame; m_rcnt = n_rcnt;
            m_code = n_code; m_valid = n_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            check(row_n == m_row(m_rcnt), "R1 row drive", int'(row_n), int'(m_row(m_rcnt)));
            check(int'(code) == m_code, "R4 key code", int'(code), m_code);
            check(valid == m_valid, "R6 strobe", int'(valid), int'(m_valid));
            if (valid) pulses++;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=150000 expected=done");
        finish_run();
    end

    initial begin : stim
        int keys [6] = '{0, 15, 10, 13, 12, 3};
        rst = 1'b1;
        run(3);
        // R8 reset state
        check(row_n == 4'b0111, "R8 reset row", int'(row_n), 7);
        check(code == 5'h1F, "R8 reset code", int'(code), 31);
        check(valid == 1'b0, "R8 reset strobe", int'(valid), 0);
        rst = 1'b0;
        run(50);
        check(code == 5'h1F, "R3 idle code", int'(code), 31);

        // key 5: row bit 1, column bit 1
        pulses = 0; mask = 16'h0001 << 5;
        run(100);
        check(code == 5'h1F, "R5 no early accept", int'(code), 31);
        run(200);
        check(code == 5'd5, "R2 key 5", int'(code), 5);
        check(pulses == 1, "R6 one strobe held", pulses, 1);

        pulses = 0; mask = '0;
        run(300);
        check(code == 5'h1F, "R7 release code", int'(code), 31);
        check(pulses == 0, "R7 no strobe release", pulses, 0);

        for (int i = 0; i < 6; i++) begin
            pulses = 0; mask = 16'h0001 << keys[i];
            run(300);
            check(int'(code) == keys[i], "R2 key map", int'(code), keys[i]);
            check(pulses == 1, "R6 strobe per key", pulses, 1);
            mask = '0;
            run(300);
        end

        // two columns low on one row
        pulses = 0; mask = (16'h0001 << 4) | (16'h0001 << 6);
        run(300);
        check(code == 5'h1F, "R3 two columns ignored", int'(code), 31);
        check(pulses == 0, "R3 no strobe two columns", pulses, 0);
        mask = '0;
        run(100);

        // bounce train on key 7
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            mask = (i % 2 == 0) ? (16'h0001 << 7) : 16'h0000;
            run(30);
        end
        check(code == 5'h1F, "R9 bounce ignored", int'(code), 31);
        check(pulses == 0, "R9 no strobe bounce", pulses, 0);
        mask = 16'h0001 << 7;
        run(300);
        check(code == 5'd7, "R9 settles key 7", int'(code), 7);
        check(pulses == 1, "R9 one strobe after settle", pulses, 1);
        mask = '0;
        run(300);

        // key to key without release
        mask = 16'h0001 << 3;
        run(300);
        pulses = 0; mask = 16'h0001 << 9;
        run(300);
        check(code == 5'd9, "R6 key change code", int'(code), 9);
        check(pulses == 0, "R6 no strobe key change", pulses, 0);
        mask = '0;
        run(300);

        // reset while a key is held
        mask = 16'h0001 << 11;
        run(300);
        check(code == 5'd11, "R2 key 11", int'(code), 11);
        rst = 1'b1;
        run(2);
        check(code == 5'h1F, "R8 reset clears code", int'(code), 31);
        check(valid == 1'b0, "R8 reset holds strobe", int'(valid), 0);
        rst = 1'b0; pulses = 0;
        run(300);
        check(code == 5'd11, "R8 reaccept after reset", int'(code), 11);
        check(pulses == 1, "R8 strobe after reset", pulses, 1);
        mask = '0;
        run(50);
        finish_run();
    end
endmodule